// File: doc/BRIEF.md
# Character Display Start-Up Sequencer

This block sits on the host side of a character display controller and carries out the software-reset start-up procedure the controller needs after power is applied. It does this without reading the busy flag. It issues instruction-register writes through a simple bus-cycle interface. It holds a write request with the value to be written until a bus engine answers with a one-cycle done pulse. Between writes it waits for a fixed number of clock cycles, and each wait is set by a parameter.

A parameter selects the bus width. On the 8-bit path every instruction goes out as one beat. On the 4-bit path only bits 7..4 of the bus carry information. The three wake-up writes and the mode switch each go out as a single nibble, and every later instruction goes out as two nibbles. The line-count, font, cursor-direction and display-scroll choices are configuration inputs, sampled while the instruction that carries them is on the bus. When the final wait has elapsed, `init_done` goes high and stays high, and normal traffic may take over the bus.

Top module: `charlcd_boot_seq`

## Requirements
- R1: After reset is released, `wr_req` and `init_done` stay low for exactly `T_POWER` cycles, and then the first request appears.
- R2: The first three writes each carry 0x30, or nibble 3 on bits 7..4 on the 4-bit path. The gaps after them are `T_WAKE1`, `T_WAKE2` and `T_CMD` cycles.
- R3: Once raised, `wr_req` and `wr_data` stay unchanged until a cycle with `wr_done` high. A `wr_done` pulse while `wr_req` is low has no effect on the sequence or its timing.
- R4: On the 8-bit path, the fourth write is the function set 0x30 with the line-count input on bit 3 and the font input on bit 2.
- R5: On the 4-bit path, the fourth write is a single nibble 0x2. Every later instruction is sent as two back-to-back beats, high nibble first, with no gap between them. The nibble is on bits 7..4 and bits 3..0 are zero. The function set byte is 0x20 with line count on bit 3 and font on bit 2.
- R6: After the function set, the sequencer sends display off (0x08), then clear (0x01), then entry mode 0x04 with the increment input on bit 1 and the scroll input on bit 0.
- R7: The gap after the clear instruction is `T_CLEAR` cycles. The gap after every other post-wake-up instruction is `T_CMD` cycles, counted from the done of its last beat.
- R8: `init_done` rises only once the gap after the entry mode write has elapsed. It then stays high, and no further request is made until reset.
- R9: Reset at any point clears `wr_req` and `init_done` and restarts the procedure from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_line | input | 1 | Line-count choice placed in the function set |
| cfg_tall_font | input | 1 | Font choice placed in the function set |
| cfg_addr_inc | input | 1 | Cursor-direction choice placed in entry mode |
| cfg_scroll | input | 1 | Display-scroll choice placed in entry mode |
| wr_req | output | 1 | Instruction write request, held until done |
| wr_data | output | 8 | Instruction byte, or nibble on bits 7..4 |
| wr_done | input | 1 | One-cycle completion pulse from the bus engine |
| init_done | output | 1 | Start-up procedure finished |

## Verification
The assertions assume that `wr_done` acknowledges a beat only in a cycle where `wr_req` is high, and that a stray pulse outside a request changes nothing. They also assume that the configuration inputs do not change while a sequence is running, and that every wait parameter is at least one. The stimulus answers each request after a latency of zero to two cycles and fires stray done pulses during the waits. It holds the configuration steady between resets and changes it only across a reset. One reset is applied in the middle of a sequence.

// File: rtl/charlcd_boot_seq.sv
module charlcd_boot_seq #(
  parameter bit          NIBBLE_BUS = 1'b0,
  parameter int unsigned T_POWER    = 1510000,
  parameter int unsigned T_WAKE1    = 420000,
  parameter int unsigned T_WAKE2    = 11000,
  parameter int unsigned T_CMD      = 3800,
  parameter int unsigned T_CLEAR    = 153000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_two_line,
  input  logic       cfg_tall_font,
  input  logic       cfg_addr_inc,
  input  logic       cfg_scroll,
  output logic       wr_req,
  output logic [7:0] wr_data,
  input  logic       wr_done,
  output logic       init_done
);

  localparam int unsigned M1   = (T_POWER > T_WAKE1) ? T_POWER : T_WAKE1;
  localparam int unsigned M2   = (T_WAKE2 > T_CMD) ? T_WAKE2 : T_CMD;
  localparam int unsigned M3   = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAXW = (M3 > T_CLEAR) ? M3 : T_CLEAR;
  localparam int          CW   = $clog2(MAXW + 1);
  localparam int          NIT  = NIBBLE_BUS ? 8 : 7;

  typedef enum logic [1:0] {ST_PWR, ST_SEND, ST_GAP, ST_DONE} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic          lo_half;

  logic [2:0]    k;
  logic [7:0]    op;
  logic [CW-1:0] gap;
  logic          single;

  assign k      = idx - {2'b00, (NIBBLE_BUS && idx >= 3'd4)};
  assign single = NIBBLE_BUS && (idx < 3'd4);

  always_comb begin
    op  = 8'h30;
    gap = CW'(T_CMD);
    if (NIBBLE_BUS && idx == 3'd3) begin
      op = 8'h20;
    end else begin
      case (k)
        3'd0: gap = CW'(T_WAKE1);
        3'd1: gap = CW'(T_WAKE2);
        3'd2: op  = 8'h30;
        3'd3: op  = {3'b001, ~NIBBLE_BUS, cfg_two_line, cfg_tall_font, 2'b00};
        3'd4: op  = 8'h08;
        3'd5: begin op = 8'h01; gap = CW'(T_CLEAR); end
        default: op = {5'b00000, 1'b1, cfg_addr_inc, cfg_scroll};
      endcase
    end
  end

  assign wr_req    = (st == ST_SEND);
  assign init_done = (st == ST_DONE);
  assign wr_data   = NIBBLE_BUS ? {(lo_half ? op[3:0] : op[7:4]), 4'h0} : op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_PWR;
      cnt     <= '0;
      idx     <= '0;
      lo_half <= 1'b0;
    end else begin
      case (st)
        ST_PWR: begin
          if (cnt == CW'(T_POWER - 1)) begin
            st  <= ST_SEND;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SEND: begin
          if (wr_done) begin
            if (NIBBLE_BUS && !single && !lo_half) begin
              lo_half <= 1'b1;
            end else begin
              lo_half <= 1'b0;
              st      <= ST_GAP;
              cnt     <= '0;
            end
          end
        end
        ST_GAP: begin
          if (cnt == gap - 1'b1) begin
            cnt <= '0;
            if (idx == 3'(NIT - 1)) begin
              st <= ST_DONE;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_SEND;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

endmodule

// File: rtl/charlcd_boot_seq_props.sv
module charlcd_boot_seq_props #(
  parameter bit          NIBBLE_BUS = 1'b0,
  parameter int unsigned T_POWER    = 1510000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req,
  input logic [7:0] wr_data,
  input logic       wr_done,
  input logic       init_done
);

  logic [31:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst < T_POWER) since_rst <= since_rst + 1'b1;
  end

  p_pwr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || init_done) |-> since_rst >= T_POWER);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_data)));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !wr_req);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wr_req && !init_done));

  generate
    if (NIBBLE_BUS) begin : g_nib
      p_nib_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_data[3:0] == 4'h0);
    end
  endgenerate

endmodule

bind charlcd_boot_seq charlcd_boot_seq_props #(
  .NIBBLE_BUS(NIBBLE_BUS),
  .T_POWER   (T_POWER)
) u_props (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_req   (wr_req),
  .wr_data  (wr_data),
  .wr_done  (wr_done),
  .init_done(init_done)
);

// File: tb/charlcd_boot_seq_bench.sv
module charlcd_boot_seq_lane #(
  parameter bit NIB = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cfg,
  output logic [31:0] checks,
  output logic [31:0] errs,
  output logic        finished
);
  localparam int P  = 20;
  localparam int W1 = 12;
  localparam int W2 = 6;
  localparam int GC = 4;
  localparam int GK = 9;

  logic       wr_req, wr_done, init_done;
  logic [7:0] wr_data;

  charlcd_boot_seq #(
    .NIBBLE_BUS(NIB), .T_POWER(P), .T_WAKE1(W1), .T_WAKE2(W2),
    .T_CMD(GC), .T_CLEAR(GK)
  ) u_charlcd_boot_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_two_line(cfg[3]), .cfg_tall_font(cfg[2]),
    .cfg_addr_inc(cfg[1]), .cfg_scroll(cfg[0]),
    .wr_req(wr_req), .wr_data(wr_data), .wr_done(wr_done),
    .init_done(init_done)
  );

  assign finished = init_done;

  int    q_data [20];
  int    q_gap  [20];
  string q_tag  [20];
  int    n, beat, idle, hold, lat, stray;

  task automatic push(input int d, input int g, input string t);
    q_data[n] = d; q_gap[n] = g; q_tag[n] = t; n++;
  endtask

  task automatic send(input int b, input int g, input string t);
    if (NIB) begin
      push(b & 8'hF0, 0, "R5");
      push((b << 4) & 8'hF0, g, t);
    end else begin
      push(b, g, t);
    end
  endtask

  task automatic build();
    int fs, ent;
    n = 0;
    fs  = (NIB ? 8'h20 : 8'h30) | (int'(cfg[3]) << 3) | (int'(cfg[2]) << 2);
    ent = 8'h04 | (int'(cfg[1]) << 1) | int'(cfg[0]);
    push(8'h30, W1, "R2");
    push(8'h30, W2, "R2");
    push(8'h30, GC, "R2");
    if (NIB) push(8'h20, GC, "R5");
    send(fs, GC, NIB ? "R5" : "R4");
    send(8'h08, GC, "R6");
    send(8'h01, GK, "R7");
    send(ent, GC, "R6");
  endtask

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s lane%0d %s: got %0h expected %0h", t, NIB, what, act, exp);
    end
  endtask

  initial begin
    checks = 0; errs = 0; wr_done = 1'b0;
    hold = 0; lat = 0; stray = 0; n = 0; beat = 0; idle = P;
  end

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      wr_done = 1'b0; hold = 0;
    end else if (wr_req) begin
      if (hold == lat) begin
        wr_done = 1'b1; hold = 0; lat = (lat + 1) % 3;
      end else begin
        wr_done = 1'b0; hold++;
      end
    end else begin
      hold = 0;
      wr_done = (stray % 5 == 0);
      stray++;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      build();
      beat = 0; idle = P;
      chk("R9", "req in reset", int'(wr_req), 0);
      chk("R9", "done in reset", int'(init_done), 0);
    end else begin
      chk(beat == 0 ? "R1" : "R3", "wr_req", int'(wr_req), int'(idle == 0 && beat < n));
      chk("R8", "init_done", int'(init_done), int'(idle == 0 && beat == n));
      if (idle == 0 && beat < n) begin
        chk(q_tag[beat], "wr_data", int'(wr_data), q_data[beat]);
        if (wr_done) begin
          idle = q_gap[beat];
          beat++;
        end
      end else if (idle > 0) begin
        idle--;
      end
    end
  end
endmodule

module charlcd_boot_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg = 4'b1010;
  logic [31:0] c8, e8, c4, e4;
  logic        f8, f4;
  int          top_checks = 0, top_errs = 0, cyc = 0;

  always #5 clk = ~clk;

  charlcd_boot_seq_lane #(.NIB(1'b0)) u_lane8 (.clk(clk), .rst_n(rst_n), .cfg(cfg),
    .checks(c8), .errs(e8), .finished(f8));
  charlcd_boot_seq_lane #(.NIB(1'b1)) u_lane4 (.clk(clk), .rst_n(rst_n), .cfg(cfg),
    .checks(c4), .errs(e4), .finished(f4));

  always @(posedge clk) cyc++;

  task automatic run_to_end(input int limit);
    while (!(f8 && f4) && cyc < limit) @(posedge clk);
    top_checks++;
    if (!(f8 && f4)) begin
      top_errs++;
      $display("FAIL R8 watchdog: got %0d%0d expected 11", f8, f4);
    end
    repeat (15) @(posedge clk);
  endtask

  task automatic do_reset(input logic [3:0] c);
    @(posedge clk); #2; rst_n = 1'b0; cfg = c;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    do_reset(4'b1010);
    run_to_end(cyc + 5000);
    do_reset(4'b0101);
    repeat (60) @(posedge clk);
    do_reset(4'b1111);
    run_to_end(cyc + 5000);
    do_reset(4'b0000);
    run_to_end(cyc + 5000);
    $display("Simulation finished: %0d checks, %0d errors",
             top_checks + c8 + c4, top_errs + e8 + e4);
    $finish;
  end
endmodule